// File: doc/BRIEF.md
# Serial Control Register Port

This block receives configuration for a camera analog front end over a three-wire serial link. The link has a clock, a frame strobe and a data line. Each frame carries 16 bits, most significant bit first. The first four bits are an address and the remaining twelve are a data word. The address selects one of five staging registers.

Values sit in staging until a frame-sync edge copies them into the active registers. The active registers drive the gain code, the auxiliary DAC code, the clamp reference, the pulse-polarity word and the extended-gain-range flag, so settings only change between frames. The polarity word itself selects which sync edge performs that copy. When a system has no frame sync, the sync input is tied to the strobe and the falling edge is selected. Each write then takes effect as soon as its frame closes.

All four serial inputs are sampled by the block's own clock, which runs well above the serial rate. Each input passes through a two-stage synchronizer, and edges are detected on the synchronized values.

Top module: `serial_ctrl_port`

## Requirements
- R1: Data is shifted in on each falling edge of `sclk` seen while `sen` is high. A rising edge of `sen` restarts the bit count. Within a frame, bits 15..12 form the address and bits 11..0 form the data word.
- R2: A frame is accepted on the falling edge of `sen` only if exactly 16 falling `sclk` edges were seen since `sen` rose. Frames with 15 or 17 edges leave every register unchanged.
- R3: Address decoding is as follows. Address 0 loads the gain code from data[7:0], address 1 loads the aux DAC code from data[7:0], and address 2 loads the clamp reference from data[6:0]. Address 3 loads all 12 bits as the polarity word, and address 4 loads the wide-range flag from data[7]. Higher data bits are dropped.
- R4: A frame addressed 5 to 15 changes neither staging nor active registers.
- R5: An accepted frame does not change the outputs until a selected `vsync` edge occurs.
- R6: Bit 8 of the active polarity word selects the load edge. When it is 0, the rising edge of `vsync` loads. When it is 1, the falling edge loads and a rising edge does nothing.
- R7: When a frame closes in the same cycle as a load edge, the active registers take the value of that frame.
- R8: Synchronous reset sets all codes and the flag to 0. It sets the polarity word to 12'h2C4 (bits 2, 6, 7 and 9 high, bit 8 low, so the rising edge loads).
- R9: A serial input level sampled at clock edge t is reflected in the outputs after edge t+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; bits are taken on its falling edge |
| sen | input | 1 | Frame strobe, high for the duration of a frame |
| sdata | input | 1 | Serial data, MSB first |
| vsync | input | 1 | Frame sync; its selected edge loads the active registers |
| gain_code | output | 8 | Active amplifier gain code |
| aux_dac_code | output | 8 | Active auxiliary DAC code |
| clamp_ref | output | 7 | Active clamp reference code |
| pulse_pol | output | 12 | Active control-pulse polarity word |
| wide_range | output | 1 | Active extended gain range flag |

## Verification
Frame acceptance and the staging-to-active load can occur in the same cycle. This happens when `vsync` is tied to `sen` and the polarity word selects the falling edge, because both events then come from one strobe edge. The bench provokes this in tied mode and checks that the gain written by that frame appears right away. A behavioural model applies the frame first and the load second within each sampled step, and the outputs are compared against this model on every clock.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int FRAME_LEN  = 16;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 12;
    localparam int CODE_W     = 8;
    localparam int CLAMP_W    = 7;
    localparam int EDGE_SEL_BIT = 8;
    localparam int RANGE_BIT    = 7;
    localparam logic [DATA_W-1:0] POL_RESET = 12'h2C4;
    localparam logic [ADDR_W-1:0] ADDR_LAST = 4'h4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_GAIN  = 4'h0,
        SEL_AUX   = 4'h1,
        SEL_CLAMP = 4'h2,
        SEL_POL   = 4'h3,
        SEL_RANGE = 4'h4
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic [CODE_W-1:0]  gain;
        logic [CODE_W-1:0]  aux;
        logic [CLAMP_W-1:0] clamp;
        logic [DATA_W-1:0]  pol;
        logic               wide;
    } ctrl_set_t;

    function automatic ctrl_set_t ctrl_reset_value();
        ctrl_set_t v;
        v.gain  = '0;
        v.aux   = '0;
        v.clamp = '0;
        v.pol   = POL_RESET;
        v.wide  = 1'b0;
        return v;
    endfunction

    function automatic ctrl_set_t apply_frame(ctrl_set_t cur, frame_t f);
        ctrl_set_t v;
        v = cur;
        case (reg_sel_e'(f.addr))
            SEL_GAIN:  v.gain  = f.data[CODE_W-1:0];
            SEL_AUX:   v.aux   = f.data[CODE_W-1:0];
            SEL_CLAMP: v.clamp = f.data[CLAMP_W-1:0];
            SEL_POL:   v.pol   = f.data;
            SEL_RANGE: v.wide  = f.data[RANGE_BIT];
            default:   v = cur;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sctl_prev.sv
module sctl_prev #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end
endmodule

// File: rtl/sctl_frame_rx.sv
module sctl_frame_rx
    import sctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sen_lvl,
    input  logic   sen_rise,
    input  logic   sen_fall,
    input  logic   sclk_fall,
    input  logic   sdata_lvl,
    output logic   commit,
    output frame_t frame
);
    localparam int CNT_W = $clog2(FRAME_LEN + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_LEN + 1);

    logic [FRAME_LEN-1:0] shreg;
    logic [CNT_W-1:0]     cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
        end else begin
            if (sclk_fall && sen_lvl) begin
                shreg <= {shreg[FRAME_LEN-2:0], sdata_lvl};
                if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
            end
            if (sen_rise) cnt <= '0;
        end
    end

    assign commit = sen_fall && (cnt == CNT_FULL);
    assign frame  = frame_t'(shreg);

    AST_SHIFT_NEEDS_SEN: assert property (@(posedge clk) disable iff (rst)
        !sen_lvl |=> $stable(shreg)); // R1
endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank
    import sctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      commit,
    input  frame_t    frame,
    input  logic      vs_rise,
    input  logic      vs_fall,
    output ctrl_set_t active
);
    ctrl_set_t stage, stage_nxt;
    logic      load;

    always_comb begin
        stage_nxt = commit ? apply_frame(stage, frame) : stage;
        load      = active.pol[EDGE_SEL_BIT] ? vs_fall : vs_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage  <= ctrl_reset_value();
            active <= ctrl_reset_value();
        end else begin
            stage <= stage_nxt;
            if (load) active <= stage_nxt;
        end
    end

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(stage)); // R2
    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (commit && (frame.addr > ADDR_LAST)) |=> $stable(stage)); // R4
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(vs_rise || vs_fall) |=> $stable(active)); // R5
    AST_LOAD_MATCHES_STAGE: assert property (@(posedge clk) disable iff (rst)
        load |=> (active == stage)); // R7
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
    import sctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk,
    input  logic                sen,
    input  logic                sdata,
    input  logic                vsync,
    output logic [CODE_W-1:0]   gain_code,
    output logic [CODE_W-1:0]   aux_dac_code,
    output logic [CLAMP_W-1:0]  clamp_ref,
    output logic [DATA_W-1:0]   pulse_pol,
    output logic                wide_range
);
    localparam int N_IN   = 4;
    localparam int N_EDGE = 3;

    logic [N_IN-1:0]   lvl;
    logic [N_EDGE-1:0] prev;
    logic              sclk_fall, sen_rise, sen_fall, vs_rise, vs_fall;
    logic              commit;
    frame_t            frame;
    ctrl_set_t         active;

    sctl_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sdata, vsync, sen, sclk}),
        .q   (lvl)
    );

    sctl_prev #(.WIDTH(N_EDGE)) u_prev (
        .clk  (clk),
        .rst  (rst),
        .cur  (lvl[N_EDGE-1:0]),
        .prev (prev)
    );

    assign sclk_fall = prev[0] & ~lvl[0];
    assign sen_rise  = ~prev[1] & lvl[1];
    assign sen_fall  = prev[1] & ~lvl[1];
    assign vs_rise   = ~prev[2] & lvl[2];
    assign vs_fall   = prev[2] & ~lvl[2];

    sctl_frame_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .sen_lvl   (lvl[1]),
        .sen_rise  (sen_rise),
        .sen_fall  (sen_fall),
        .sclk_fall (sclk_fall),
        .sdata_lvl (lvl[3]),
        .commit    (commit),
        .frame     (frame)
    );

    sctl_regbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .frame   (frame),
        .vs_rise (vs_rise),
        .vs_fall (vs_fall),
        .active  (active)
    );

    assign gain_code    = active.gain;
    assign aux_dac_code = active.aux;
    assign clamp_ref    = active.clamp;
    assign pulse_pol    = active.pol;
    assign wide_range   = active.wide;
endmodule

// File: tb/test_serial_ctrl_port.sv
module test_serial_ctrl_port;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 4;
    localparam logic [35:0] RST_VEC = {8'h00, 8'h00, 7'h00, 12'h2C4, 1'b0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic b_sclk = 1'b0, b_sen = 1'b0, b_sdata = 1'b0, b_vsync = 1'b0;
    logic [7:0]  gain_code, aux_dac_code;
    logic [6:0]  clamp_ref;
    logic [11:0] pulse_pol;
    logic        wide_range;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R8";

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_ctrl_port i_serial_ctrl_port (
        .clk          (clk),
        .rst          (rst),
        .sclk         (b_sclk),
        .sen          (b_sen),
        .sdata        (b_sdata),
        .vsync        (b_vsync),
        .gain_code    (gain_code),
        .aux_dac_code (aux_dac_code),
        .clamp_ref    (clamp_ref),
        .pulse_pol    (pulse_pol),
        .wide_range   (wide_range)
    );

    // behavioural reference model
    logic [7:0]  s_gain, s_aux, a_gain, a_aux;
    logic [6:0]  s_clamp, a_clamp;
    logic [11:0] s_pol, a_pol;
    logic        s_wide, a_wide;
    logic [15:0] m_sh;
    int          m_cnt;
    logic        p_sclk, p_sen, p_vs;
    logic [35:0] hist [3];

    always @(posedge clk) begin
        if (rst) begin
            s_gain = 0; s_aux = 0; s_clamp = 0; s_pol = 12'h2C4; s_wide = 0;
            a_gain = 0; a_aux = 0; a_clamp = 0; a_pol = 12'h2C4; a_wide = 0;
            m_sh = 0; m_cnt = 0; p_sclk = 0; p_sen = 0; p_vs = 0;
            for (int i = 0; i < 3; i++) hist[i] = RST_VEC;
        end else begin
            logic do_load;
            if (p_sclk && !b_sclk && b_sen) begin
                m_sh = {m_sh[14:0], b_sdata};
                if (m_cnt < 17) m_cnt++;
            end
            if (!p_sen && b_sen) m_cnt = 0;
            if (p_sen && !b_sen && m_cnt == 16 && !(p_sclk && !b_sclk && b_sen)) begin
                case (m_sh[15:12])
                    4'd0: s_gain  = m_sh[7:0];
                    4'd1: s_aux   = m_sh[7:0];
                    4'd2: s_clamp = m_sh[6:0];
                    4'd3: s_pol   = m_sh[11:0];
                    4'd4: s_wide  = m_sh[7];
                    default: ;
                endcase
            end
            do_load = a_pol[8] ? (p_vs && !b_vsync) : (!p_vs && b_vsync);
            if (do_load) begin
                a_gain = s_gain; a_aux = s_aux; a_clamp = s_clamp;
                a_pol = s_pol; a_wide = s_wide;
            end
            p_sclk = b_sclk; p_sen = b_sen; p_vs = b_vsync;
            hist[2] = hist[1];
            hist[1] = hist[0];
            hist[0] = {a_gain, a_aux, a_clamp, a_pol, a_wide};
        end
    end

    function automatic logic [35:0] dut_vec();
        return {gain_code, aux_dac_code, clamp_ref, pulse_pol, wide_range};
    endfunction

    task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, two-edge delay (R9)
    always @(negedge clk) begin
        if (!rst) chk({"R9/", cur_req}, dut_vec(), hist[2]);
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(int nbits, logic [15:0] w, bit tie);
        b_sen = 1'b1;
        if (tie) b_vsync = 1'b1;
        wait_n(HOLD);
        for (int i = 0; i < nbits; i++) begin
            b_sdata = (i < 16) ? w[15-i] : 1'b0;
            b_sclk = 1'b1;
            wait_n(HOLD);
            b_sclk = 1'b0;
            wait_n(HOLD);
        end
        b_sen = 1'b0;
        if (tie) b_vsync = 1'b0;
        wait_n(HOLD);
    endtask

    task automatic vs_pulse();
        b_vsync = 1'b1;
        wait_n(HOLD);
        b_vsync = 1'b0;
        wait_n(HOLD);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(3);
        cur_req = "R8";
        chk("R8 reset state", dut_vec(), RST_VEC);

        // R1 R5: staged gain invisible until rising vsync
        cur_req = "R5";
        send_frame(16, 16'h005A, 0);
        chk("R5 gain before load", {28'h0, gain_code}, 36'h5A & 36'h0);
        vs_pulse();
        cur_req = "R1";
        chk("R1 gain after load", {28'h0, gain_code}, 36'h5A);

        // R3 decoding of aux, clamp, range
        cur_req = "R3";
        send_frame(16, 16'h1FC3, 0);
        send_frame(16, 16'h20FF, 0);
        send_frame(16, 16'h4080, 0);
        vs_pulse();
        chk("R3 aux code", {28'h0, aux_dac_code}, 36'hC3);
        chk("R3 clamp code", {29'h0, clamp_ref}, 36'h7F);
        chk("R3 wide flag", {35'h0, wide_range}, 36'h1);
        chk("R3 gain kept", {28'h0, gain_code}, 36'h5A);

        // R4 test addresses
        cur_req = "R4";
        send_frame(16, 16'h7FFF, 0);
        send_frame(16, 16'hF000, 0);
        vs_pulse();
        chk("R4 state unchanged", dut_vec(), {8'h5A, 8'hC3, 7'h7F, 12'h2C4, 1'b1});

        // R2 wrong-length frames discarded
        cur_req = "R2";
        send_frame(15, 16'h0011, 0);
        send_frame(17, 16'h0022, 0);
        vs_pulse();
        chk("R2 gain unchanged", {28'h0, gain_code}, 36'h5A);

        // R6 select falling edge via polarity word
        cur_req = "R6";
        send_frame(16, 16'h33C4, 0);
        vs_pulse();
        chk("R6 polarity loaded", {24'h0, pulse_pol}, 36'h3C4);
        send_frame(16, 16'h0033, 0);
        b_vsync = 1'b1;
        wait_n(HOLD);
        chk("R6 rising ignored", {28'h0, gain_code}, 36'h5A);
        b_vsync = 1'b0;
        wait_n(HOLD);
        chk("R6 falling loads", {28'h0, gain_code}, 36'h33);

        // R7 tied sync: frame and load in the same cycle
        cur_req = "R7";
        send_frame(16, 16'h0077, 1);
        chk("R7 immediate gain", {28'h0, gain_code}, 36'h77);
        send_frame(16, 16'h10A5, 1);
        chk("R7 immediate aux", {28'h0, aux_dac_code}, 36'hA5);

        // R8 reset again mid-run
        cur_req = "R8";
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
        wait_n(2);
        chk("R8 reset restores", dut_vec(), RST_VEC);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule